// File: doc/BRIEF.md
# Cross-Processor Doorbell Interrupt Controller

This block lets one processor signal another through 32 software-generated interrupt sources. Software reaches it over a simple synchronous register bus with an address, a write strobe, write data, a read strobe and read data. Writes to four command registers act only on the bits written as 1. They set or clear pending sources and enable or disable mask bits. Writes to the command registers never store the written word itself.

Three read-only status registers return the mask, the pending set and the pending-and-enabled set. A single level interrupt output comes from a flop. It is high while any source is both pending and enabled. The receiving processor usually reads the status register, services the sources it finds there, and then clears them through the clear command.

Top module: `xcpu_doorbell`

## Requirements
- R1: After reset all pending bits and all mask bits are 0, and `irq_o` is low.
- R2: A write to offset 0x00 makes pending every source whose data bit is 1. Sources whose bit is 0 keep their state. The change takes effect on the clock edge of the write.
- R3: A write to offset 0x04 clears the pending state of every source whose data bit is 1. Sources whose bit is 0 keep their state. The change takes effect on the clock edge of the write.
- R4: A write to offset 0x08 sets the mask bit of every source whose data bit is 1. A write to offset 0x0C clears the mask bit of every source whose data bit is 1. All other mask bits keep their state.
- R5: Reading offset 0x10 returns the mask, which is the cumulative result of enable and disable writes. Bit n belongs to source n.
- R6: Reading offset 0x14 returns the pending set. Bit n belongs to source n.
- R7: Reading offset 0x18 returns the bitwise AND of the pending set and the mask.
- R8: `irq_o` is registered. In each cycle it equals the OR of (pending AND mask) as that value stood in the previous cycle, so a command changes the line one cycle after its write edge.
- R9: A pending source whose mask bit is 0 never raises `irq_o`. It also does not stop another source that is pending and enabled from raising it.
- R10: Writes to offsets 0x10, 0x14, 0x18 and to unmapped addresses change no state. Command offsets and unmapped addresses read as 0.
- R11: `rd_data` shows the addressed register in the same cycle as `rd_en`. It is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address of the register |
| wr_data | input | 32 | Write data; bit n selects source n |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Registered level interrupt line |

## Verification
A wrong pending or mask bit becomes visible on the next read of the mask, pending or status register. A wrong pending or mask bit that is both pending and enabled, or that hides the only such source, also appears one cycle later as a wrong level on `irq_o`. The bench therefore compares `irq_o` against its model in every cycle. It also reads back all three status registers after each group of commands, so a bad bit is caught within a few cycles of the write that caused it. Off-by-one timing on the output flop shows at the first edge after any command that changes the pending-and-enabled set.

// File: rtl/xcpu_doorbell_pkg.sv
package xcpu_doorbell_pkg;
  localparam int unsigned OFF_SET   = 'h00;
  localparam int unsigned OFF_CLR   = 'h04;
  localparam int unsigned OFF_EN    = 'h08;
  localparam int unsigned OFF_DIS   = 'h0C;
  localparam int unsigned OFF_MASK  = 'h10;
  localparam int unsigned OFF_PEND  = 'h14;
  localparam int unsigned OFF_STAT  = 'h18;

  // Next value of one state bit: a set request wins over a clear request.
  function automatic logic next_bit(input logic cur, input logic set_r, input logic clr_r);
    next_bit = set_r | (cur & ~clr_r);
  endfunction

  // Sources that currently drive the output line.
  function automatic logic [31:0] active_of(input logic [31:0] pend, input logic [31:0] mask);
    active_of = pend & mask;
  endfunction
endpackage

// File: rtl/xcpu_doorbell_decode.sv
module xcpu_doorbell_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NSRC   = 32
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wr_data,
  output logic [NSRC-1:0]   pend_set,
  output logic [NSRC-1:0]   pend_clr,
  output logic [NSRC-1:0]   mask_set,
  output logic [NSRC-1:0]   mask_clr
);
  import xcpu_doorbell_pkg::*;

  logic hit_set, hit_clr, hit_en, hit_dis;

  always_comb begin
    hit_set = wr_en && (addr == ADDR_W'(OFF_SET));
    hit_clr = wr_en && (addr == ADDR_W'(OFF_CLR));
    hit_en  = wr_en && (addr == ADDR_W'(OFF_EN));
    hit_dis = wr_en && (addr == ADDR_W'(OFF_DIS));
    pend_set = hit_set ? wr_data : '0;
    pend_clr = hit_clr ? wr_data : '0;
    mask_set = hit_en  ? wr_data : '0;
    mask_clr = hit_dis ? wr_data : '0;
  end
endmodule

// File: rtl/xcpu_doorbell_bank.sv
module xcpu_doorbell_bank #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_req,
  input  logic [NSRC-1:0] clr_req,
  output logic [NSRC-1:0] state_q
);
  import xcpu_doorbell_pkg::*;

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= next_bit(bit_q, set_req[g], clr_req[g]);
    end
    assign state_q[g] = bit_q;
  end
endmodule

// File: rtl/xcpu_doorbell_line.sv
module xcpu_doorbell_line #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] active,
  output logic            irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |active;
  end
endmodule

// File: rtl/xcpu_doorbell.sv
module xcpu_doorbell #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NSRC   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wr_data,
  input  logic              rd_en,
  output logic [NSRC-1:0]   rd_data,
  output logic              irq_o
);
  import xcpu_doorbell_pkg::*;

  logic [NSRC-1:0] pend_set, pend_clr, mask_set, mask_clr;
  logic [NSRC-1:0] pend_q, mask_q, active;

  xcpu_doorbell_decode #(.ADDR_W(ADDR_W), .NSRC(NSRC)) u_dec (
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .mask_set(mask_set), .mask_clr(mask_clr)
  );

  xcpu_doorbell_bank #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_req(pend_set), .clr_req(pend_clr), .state_q(pend_q)
  );

  xcpu_doorbell_bank #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_req(mask_set), .clr_req(mask_clr), .state_q(mask_q)
  );

  assign active = pend_q & mask_q;

  xcpu_doorbell_line #(.NSRC(NSRC)) u_line (
    .clk(clk), .rst_n(rst_n), .active(active), .irq_q(irq_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if      (addr == ADDR_W'(OFF_MASK)) rd_data = mask_q;
      else if (addr == ADDR_W'(OFF_PEND)) rd_data = pend_q;
      else if (addr == ADDR_W'(OFF_STAT)) rd_data = active;
    end
  end
endmodule

// File: rtl/xcpu_doorbell_chk.sv
module xcpu_doorbell_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NSRC   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wr_data,
  input logic              rd_en,
  input logic [NSRC-1:0]   rd_data,
  input logic              irq_o,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   mask_q
);
  import xcpu_doorbell_pkg::*;

  logic w_set, w_clr, w_en, w_dis;
  assign w_set = wr_en && addr == ADDR_W'(OFF_SET);
  assign w_clr = wr_en && addr == ADDR_W'(OFF_CLR);
  assign w_en  = wr_en && addr == ADDR_W'(OFF_EN);
  assign w_dis = wr_en && addr == ADDR_W'(OFF_DIS);

  AST_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> ((pend_q & $past(wr_data)) == $past(wr_data))); // R2
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> ((pend_q & ~$past(wr_data)) == ($past(pend_q) & ~$past(wr_data)))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> ((pend_q & $past(wr_data)) == '0)); // R3
  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    w_en |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R4
  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    w_dis |=> ((mask_q & $past(wr_data)) == '0)); // R4
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_en || w_dis) |=> $stable(mask_q)); // R10
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_set || w_clr) |=> $stable(pend_q)); // R10
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFF_STAT)) |-> (rd_data == (pend_q & mask_q))); // R7
  AST_LINE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == (|$past(pend_q & mask_q)))); // R8
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0)); // R11
endmodule

bind xcpu_doorbell xcpu_doorbell_chk #(.ADDR_W(ADDR_W), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/xcpu_doorbell_tb.sv
`timescale 1ns/1ps
module xcpu_doorbell_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit [31:0] m_pend = '0;
  bit [31:0] m_mask = '0;
  bit        m_irq  = 1'b0;

  always #4 clk = ~clk;

  xcpu_doorbell u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference update at each edge, inputs were set at the previous falling edge
  always @(posedge clk) begin
    bit [31:0] np, nm;
    if (!rst_n) begin
      m_pend = '0; m_mask = '0; m_irq = 1'b0;
    end else begin
      np = m_pend; nm = m_mask;
      m_irq = ((m_pend & m_mask) != 0);
      if (wr_en) begin
        case (addr)
          8'h00: for (int i = 0; i < 32; i++) if (wr_data[i]) np[i] = 1'b1;
          8'h04: for (int i = 0; i < 32; i++) if (wr_data[i]) np[i] = 1'b0;
          8'h08: for (int i = 0; i < 32; i++) if (wr_data[i]) nm[i] = 1'b1;
          8'h0C: for (int i = 0; i < 32; i++) if (wr_data[i]) nm[i] = 1'b0;
          default: ;
        endcase
      end
      m_pend = np; m_mask = nm;
    end
  end

  // line compared against the model every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) check("R8 irq_o", {31'b0, irq_o}, {31'b0, m_irq});
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] expect_at(input logic [7:0] a);
    case (a)
      8'h10: return m_mask;
      8'h14: return m_pend;
      8'h18: return m_pend & m_mask;
      default: return '0;
    endcase
  endfunction

  task automatic rd(input string tag, input logic [7:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 check(tag, rd_data, expect_at(a));
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    rd({tag, " mask R5"}, 8'h10);
    rd({tag, " pend R6"}, 8'h14);
    rd({tag, " status R7"}, 8'h18);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check("R1 irq_o", {31'b0, irq_o}, 32'h0);
    rd_all("R1");

    // R2 set pends selected bits, R9 masked source keeps line low
    wr(8'h00, 32'h8000_0011);
    rd("R2 pend after set", 8'h14);
    @(negedge clk); #1 check("R9 masked pending line low", {31'b0, irq_o}, 32'h0);
    wr(8'h00, 32'h0000_0100);
    rd("R2 set keeps others", 8'h14);

    // R4 enable, R8 timing checked directly one cycle after write edge
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h08; wr_data = 32'h0000_0010;
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R8 line low in write cycle+0", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    #1 check("R8 line high one cycle later", {31'b0, irq_o}, 32'h1);
    rd_all("R4 enable");

    // R9 another masked pending source does not block servicing
    wr(8'h08, 32'h0000_0001);
    wr(8'h0C, 32'h0000_0010);
    rd_all("R9 mixed");
    @(negedge clk); #1 check("R9 line from source 0", {31'b0, irq_o}, 32'h1);

    // R3 clear selected pending bits
    wr(8'h04, 32'h0000_0001);
    rd_all("R3 clear");
    @(negedge clk); #1 check("R3 line drops", {31'b0, irq_o}, 32'h0);
    wr(8'h04, 32'h0000_0000);
    rd("R3 zero word no effect", 8'h14);

    // R10 writes to status and unmapped addresses are ignored
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd_all("R10 ignored writes");
    rd("R10 set reads zero", 8'h00);
    rd("R10 clr reads zero", 8'h04);
    rd("R10 en reads zero", 8'h08);
    rd("R10 dis reads zero", 8'h0C);
    rd("R10 unmapped reads zero", 8'h20);

    // R11 read data idle without strobe
    @(negedge clk); addr = 8'h14; rd_en = 1'b0;
    #1 check("R11 idle rd_data", rd_data, 32'h0);

    // walking patterns across all sources
    for (int i = 0; i < 32; i++) begin
      wr(8'h08, 32'h1 << i);
      wr(8'h00, 32'h1 << ((i + 5) % 32));
      if (i % 4 == 0) wr(8'h0C, 32'h1 << ((i + 9) % 32));
      if (i % 3 == 0) wr(8'h04, 32'h1 << ((i + 1) % 32));
      rd_all("R2 R4 walk");
    end
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_all("R7 all active");
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hA5A5_A5A5);
    rd_all("R5 cumulative mask");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule